// File: doc/BRIEF.md
# Key-Protected Clock Source Select Register

This block is one control register of an always-on clock domain. It holds two one-bit clock source selects and one gate enable for an external 32 kHz crystal input. The first select chooses the low-frequency clock: the clock derived from the internal RC oscillator, or the gated crystal. The second select chooses the timekeeping clock: the low-frequency clock, or a 32 kHz clock derived from the 24 MHz oscillator.

Software writes the register over a simple bus with address, write data and byte strobes, and reads it back through a read data port. The two select bits are protected by a key. A write moves them only when the upper half-word of the same write carries the key value 0x16AA. The key field always reads as zero, so every read-modify-write must OR the key back in. Each select and the gate enable pass through a synchroniser clocked by the always-on clock before they steer the clock muxes. Glitch-free switching is modelled only as this synchronisation.

Top module: `keyed_clksel_reg`

## Requirements
- R1: After reset the register reads 0x00000000, both muxes pass the internal-RC-derived clock, and the crystal gate is closed.
- R2: A write to offset 0 with strobe bit 0 set, strobe bits 3 and 2 both set and wdata[31:16] equal to 0x16AA loads wdata[0] into the low-frequency select and wdata[1] into the timekeeping select.
- R3: A write to offset 0 whose key is wrong leaves both select bits unchanged. The key is wrong when either upper strobe is clear or wdata[31:16] is not 0x16AA.
- R4: Bit 4, the crystal gate enable, loads from wdata[4] on every write to offset 0 with strobe bit 0 set when GATE_WRITE_ON_BAD_KEY is 1. When that parameter is 0, it loads only on a keyed write.
- R5: A read of offset 0 returns gate enable in bit 4, the timekeeping select in bit 1 and the low-frequency select in bit 0. All other bits, including the key field in bits 31:16, read as zero.
- R6: A write with strobe bit 0 clear, or a write to any nonzero offset, changes nothing. A read of any nonzero offset returns zero.
- R7: Low-frequency select 0 passes the RC-derived clock and 1 passes the crystal ANDed with the gate enable. Timekeeping select 0 passes the low-frequency clock and 1 passes the 24 MHz-derived clock. With the crystal selected and the gate off, the output carries no edges.
- R8: Each select and the gate enable reach the muxes through SYNC_STAGES flops clocked by the always-on clock, so a change shows at the mux outputs after a few always-on cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request for this cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write strobes |
| rdata | output | 32 | Read data for addr |
| aon_clk | input | 1 | Always-on clock for the select synchronisers |
| rc32k_clk | input | 1 | Internal-RC-derived 32 kHz clock |
| xtal32k_clk | input | 1 | External 32 kHz crystal clock |
| hf32k_clk | input | 1 | 32 kHz clock derived from 24 MHz |
| lf_clk_out | output | 1 | Low-frequency mux output |
| tk_clk_out | output | 1 | Timekeeping mux output |

## Verification
The bench builds two copies of the block on the same bus: one with GATE_WRITE_ON_BAD_KEY at 1 and one at 0, both with SYNC_STAGES of 2. A wrong-key write that sets the gate then leaves the two copies in different states. This shows both gate policies through read-back and through edge counts on the timekeeping output. The mux input clocks run at three distinct periods, so counting output edges over a fixed window shows which source each select setting picked after every switch.

// File: rtl/keyed_clksel_reg.sv
module keyed_clksel_reg #(
  parameter int          ADDR_W                = 8,
  parameter logic [15:0] KEY                   = 16'h16AA,
  parameter bit          GATE_WRITE_ON_BAD_KEY = 1'b1,
  parameter int          SYNC_STAGES           = 2
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  output logic [31:0]       rdata,
  input  logic              aon_clk,
  input  logic              rc32k_clk,
  input  logic              xtal32k_clk,
  input  logic              hf32k_clk,
  output logic              lf_clk_out,
  output logic              tk_clk_out
);

  logic       hit, key_ok, gate_wr;
  logic [1:0] sel_q;
  logic       gate_q;
  logic [SYNC_STAGES-1:0] lf_sync, tk_sync, gate_sync;
  logic       unused_bits;

  assign hit     = wr_en && (addr == '0) && wstrb[0];
  assign key_ok  = (&wstrb[3:2]) && (wdata[31:16] == KEY);
  assign gate_wr = hit && (key_ok || GATE_WRITE_ON_BAD_KEY);
  assign unused_bits = ^{wdata[15:5], wdata[3:2], wstrb[1]};

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 2'b00;
      gate_q <= 1'b0;
    end else begin
      if (hit && key_ok) sel_q <= wdata[1:0];
      if (gate_wr)       gate_q <= wdata[4];
    end
  end

  assign rdata = (addr == '0) ? {27'd0, gate_q, 2'b00, sel_q} : 32'd0;

  always_ff @(posedge aon_clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_sync   <= '0;
      tk_sync   <= '0;
      gate_sync <= '0;
    end else begin
      lf_sync   <= {lf_sync[SYNC_STAGES-2:0], sel_q[0]};
      tk_sync   <= {tk_sync[SYNC_STAGES-2:0], sel_q[1]};
      gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_q};
    end
  end

  assign lf_clk_out = lf_sync[SYNC_STAGES-1] ? (xtal32k_clk & gate_sync[SYNC_STAGES-1]) : rc32k_clk;
  assign tk_clk_out = tk_sync[SYNC_STAGES-1] ? hf32k_clk : lf_clk_out;

  AST_KEY_LOADS_SEL: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (hit && key_ok) |=> (sel_q == $past(wdata[1:0])));  // R2
  AST_BAD_KEY_KEEPS_SEL: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && !(hit && key_ok)) |=> $stable(sel_q));  // R3
  AST_GATE_LOADS: assert property (@(posedge bus_clk) disable iff (!rst_n)
    gate_wr |=> (gate_q == $past(wdata[4])));  // R4
  AST_GATE_HELD: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !gate_wr |=> $stable(gate_q));  // R6
  AST_IDLE_HOLDS: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sel_q) && $stable(gate_q)));  // R6

endmodule

// File: tb/test_keyed_clksel_reg.sv
`timescale 1ns/1ps
module test_keyed_clksel_reg;
  logic bus_clk = 0, aon_clk = 0, rc = 0, xt = 0, hf = 0;
  logic rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic [31:0] rdata_a, rdata_b;
  logic lf_a, tk_a, lf_b, tk_b;

  always #2.5 bus_clk = ~bus_clk;
  always #5   aon_clk = ~aon_clk;
  always #20  rc = ~rc;
  always #30  xt = ~xt;
  always #50  hf = ~hf;

  keyed_clksel_reg #(.GATE_WRITE_ON_BAD_KEY(1'b1)) i_keyed_clksel_reg (
    .bus_clk, .rst_n, .wr_en, .addr, .wdata, .wstrb, .rdata(rdata_a), .aon_clk,
    .rc32k_clk(rc), .xtal32k_clk(xt), .hf32k_clk(hf), .lf_clk_out(lf_a), .tk_clk_out(tk_a));
  keyed_clksel_reg #(.GATE_WRITE_ON_BAD_KEY(1'b0)) i_keyed_clksel_reg_strict (
    .bus_clk, .rst_n, .wr_en, .addr, .wdata, .wstrb, .rdata(rdata_b), .aon_clk,
    .rc32k_clk(rc), .xtal32k_clk(xt), .hf32k_clk(hf), .lf_clk_out(lf_b), .tk_clk_out(tk_b));

  int checks = 0, errors = 0;
  typedef struct { logic [31:0] ea; logic [31:0] eb; string tag; } item_t;
  item_t q[$];
  logic rd_flag = 0;
  logic [31:0] m_a = 0, m_b = 0;
  int cnt_a = 0, cnt_b = 0;
  logic counting = 0;
  logic done = 0;

  always @(posedge tk_a) if (counting) cnt_a++;
  always @(posedge tk_b) if (counting) cnt_b++;

  always @(negedge bus_clk) if (rd_flag && q.size() > 0) begin
    item_t it;
    it = q.pop_front();
    checks++;
    if (rdata_a !== it.ea) begin
      errors++;
      $display("FAIL %s lenient read: got %h expected %h", it.tag, rdata_a, it.ea);
    end
    checks++;
    if (rdata_b !== it.eb) begin
      errors++;
      $display("FAIL %s strict read: got %h expected %h", it.tag, rdata_b, it.eb);
    end
  end

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic hit, kok;
    hit = (a == 0) && s[0];
    kok = (s[3:2] == 2'b11) && (d[31:16] == 16'h16AA);
    if (hit && kok) begin m_a[1:0] = d[1:0]; m_b[1:0] = d[1:0]; end
    if (hit) m_a[4] = d[4];
    if (hit && kok) m_b[4] = d[4];
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(posedge bus_clk); #1;
    wr_en = 1; addr = a; wdata = d; wstrb = s;
    @(posedge bus_clk); #1;
    wr_en = 0; wstrb = 0; wdata = 0;
    model_wr(a, d, s);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    item_t it;
    @(posedge bus_clk); #1;
    addr = a;
    it.ea = (a == 0) ? m_a : 32'd0;
    it.eb = (a == 0) ? m_b : 32'd0;
    it.tag = tag;
    q.push_back(it);
    rd_flag = 1;
    @(posedge bus_clk); #1;
    rd_flag = 0;
    addr = 0;
  endtask

  function automatic int expect_edges(input logic [31:0] m);
    if (m[1]) return 12;
    if (m[0]) return m[4] ? 20 : 0;
    return 30;
  endfunction

  task automatic chk_freq(input string tag);
    int ea, eb;
    #200;
    cnt_a = 0; cnt_b = 0; counting = 1;
    #1200;
    counting = 0;
    ea = expect_edges(m_a); eb = expect_edges(m_b);
    checks++;
    if (cnt_a < ea - 1 || cnt_a > ea + 1) begin
      errors++;
      $display("FAIL %s lenient edges: got %0d expected %0d", tag, cnt_a, ea);
    end
    checks++;
    if (cnt_b < eb - 1 || cnt_b > eb + 1) begin
      errors++;
      $display("FAIL %s strict edges: got %0d expected %0d", tag, cnt_b, eb);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1;
    rd(8'h00, "R1 reset");
    chk_freq("R1 reset rc path");
    wr(8'h00, 32'h16AA_0011, 4'b1101);
    rd(8'h00, "R2 keyed xtal");
    chk_freq("R7 R8 xtal gated on");
    wr(8'h00, 32'h16AA_0013, 4'b1101);
    rd(8'h00, "R2 keyed hf");
    chk_freq("R7 hf path");
    wr(8'h00, 32'h1234_0010, 4'b1101);
    rd(8'h00, "R3 bad key value");
    chk_freq("R3 sel held");
    wr(8'h00, 32'h16AA_0001, 4'b0001);
    rd(8'h00, "R3 key without upper strobes");
    wr(8'h00, 32'h16AA_0001, 4'b1101);
    rd(8'h00, "R5 key reads zero");
    chk_freq("R7 gate off no edges");
    wr(8'h00, 32'h5555_0010, 4'b1101);
    rd(8'h00, "R4 gate policy bad key");
    chk_freq("R4 gate policy edges");
    wr(8'h00, 32'h16AA_0000, 4'b1100);
    rd(8'h00, "R6 strobe0 clear");
    wr(8'h04, 32'h16AA_0002, 4'b1111);
    rd(8'h04, "R6 other offset reads zero");
    rd(8'h00, "R6 other offset no write");
    wr(8'h00, 32'h16AA_0000, 4'b1111);
    rd(8'h00, "R2 back to rc");
    chk_freq("R8 back to rc");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule